// File: doc/BRIEF.md
# Local Interrupt Control/Status Unit

This unit merges two asynchronous local interrupt lines and a software-raised request into one active-low bus interrupt output. Each local line is first brought into the clock domain by a two-flop synchronizer. It is then qualified in one of two ways. In level mode the active polarity can be chosen, and the request follows the line. In latched mode a rising edge sets a sticky request, and software must remove it.

One 32-bit control/status word sets up all of this. A register port with a write strobe, write data, per-byte write enables and a combinational read-data bus reads and writes the word. The field layout is as follows. Bit 0 enables line 1, bit 1 sets its polarity (1 = active-high, 0 = active-low) and bit 2 is its status. Bits 3, 4 and 5 do the same for line 2. Bit 6 is the master output enable and bit 7 is the software request. Bits 8 and 9 select latched mode for lines 1 and 2. Bits 10 and 11 are write-one clear commands for the latched requests of lines 1 and 2. Write enable bit 0 covers bits 7:0 and write enable bit 1 covers bits 15:8. All control bits reset to 0.

Top module: `lirq_unit`

## Requirements
- R1: After reset the read word is 0x0000_0000 and the interrupt output is high (deasserted).
- R2: In level mode with polarity bit 1, an enabled line's status bit is 1 while the synchronized line is high and 0 while it is low.
- R3: In level mode with polarity bit 0, an enabled line's status bit is 1 while the synchronized line is low and 0 while it is high.
- R4: While a line's enable bit is 0, its status bit reads 0 and the line cannot pull the output low.
- R5: While bit 6 is 0 the output stays high, whatever the status bits and bit 7 hold.
- R6: With bit 6 set, writing 1 to bit 7 drives the output low. Writing bit 7 back to 0 releases it when no other source is active.
- R7: In latched mode (bit 8 or 9 set), a rising edge on an enabled line sets its status bit. The bit stays set after the line falls, and the polarity bit has no effect.
- R8: Writing 1 to bit 10 or 11 (with write enable bit 1) clears the matching latched request. These bits always read as 0.
- R9: If a rising edge is detected in the same cycle as a clear command for that line, the latched request stays set.
- R10: Clearing a line's enable bit drops its latched request. Setting the enable again while the line stays high does not bring the request back.
- R11: A write only changes bits in bytes whose write enable is 1.
- R12: A line change shows in its status bit after two rising clock edges. The output follows the status with one more edge of delay.
- R13: Bits 12 to 31 always read 0, and the status bits 2 and 5 cannot be written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_raw | input | 2 | Asynchronous local interrupt lines; index 0 is line 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_be | input | 4 | Per-byte write enables |
| reg_rdata | output | 32 | Register read data with live status |
| irq_out_n | output | 1 | Registered active-low bus interrupt |

## Verification
The bench drives a clear command in exactly the cycle in which the synchronized rising edge is detected. A design that lets the clear win would drop a fresh interrupt there. It disables and then re-enables a latched line while the line stays high, which exposes a design that only masks the latch instead of clearing it. It times the status and output against the synchronizer and output register edge by edge, so a missing or extra stage shows up as a one-cycle mismatch. It also switches polarity, the master enable and the software bit on a live source, and writes all-ones through single-byte enables to catch a stray write, a writable status bit or a nonzero reserved bit.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int NUM_SRC   = 2;
  localparam int REG_W     = 32;
  localparam int BE_W      = REG_W / 8;

  // Control/status word field positions (line 1 / line 2)
  localparam int B_EN1     = 0;
  localparam int B_POL1    = 1;
  localparam int B_STAT1   = 2;
  localparam int B_EN2     = 3;
  localparam int B_POL2    = 4;
  localparam int B_STAT2   = 5;
  localparam int B_MEN     = 6;
  localparam int B_SWI     = 7;
  localparam int B_EDGE1   = 8;
  localparam int B_EDGE2   = 9;
  localparam int B_CLR1    = 10;
  localparam int B_CLR2    = 11;

  typedef struct packed {
    logic en;
    logic pol_high;
    logic edge_md;
  } src_cfg_t;
endpackage

// File: rtl/lirq_rst_sync.sv
module lirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lirq_sync.sv
module lirq_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (g == 0) begin : g_first
        always_comb stage_d = async_in;
      end else begin : g_next
        always_comb stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/lirq_source.sv
module lirq_source
  import lirq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     line_s,
  input  src_cfg_t cfg,
  input  logic     clr,
  output logic     req
);
  logic line_prev_q;
  logic latch_q;
  logic latch_d;
  logic rise;
  logic level_act;

  always_comb begin
    rise      = line_s & ~line_prev_q;
    level_act = cfg.pol_high ? line_s : ~line_s;
    if (!cfg.en || !cfg.edge_md) latch_d = 1'b0;
    else if (rise)               latch_d = 1'b1;
    else if (clr)                latch_d = 1'b0;
    else                         latch_d = latch_q;
    req = cfg.en & (cfg.edge_md ? latch_q : level_act);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_prev_q <= 1'b0;
      latch_q     <= 1'b0;
    end else begin
      line_prev_q <= line_s;
      latch_q     <= latch_d;
    end
  end

  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && cfg.edge_md && req && !clr) |=> latch_q);

  assert_clr_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && cfg.edge_md && clr && !rise) |=> !latch_q);

  assert_rise_beats_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && cfg.edge_md && rise && clr) |=> latch_q);

  assert_disable_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.en) |=> !latch_q);
endmodule

// File: rtl/lirq_csr.sv
module lirq_csr
  import lirq_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [REG_W-1:0]              wdata,
  input  logic [BE_W-1:0]               be,
  input  logic [NUM_SRC-1:0]            status,
  output src_cfg_t [NUM_SRC-1:0]        cfg,
  output logic [NUM_SRC-1:0]            clr,
  output logic                          men,
  output logic                          swi,
  output logic [REG_W-1:0]              rdata
);
  logic [NUM_SRC-1:0] en_q,   en_d;
  logic [NUM_SRC-1:0] pol_q,  pol_d;
  logic [NUM_SRC-1:0] edge_q, edge_d;
  logic               men_q,  men_d;
  logic               swi_q,  swi_d;
  logic               wr_lo, wr_hi;

  always_comb begin
    wr_lo  = wr & be[0];
    wr_hi  = wr & be[1];
    en_d   = en_q;
    pol_d  = pol_q;
    edge_d = edge_q;
    men_d  = men_q;
    swi_d  = swi_q;
    if (wr_lo) begin
      en_d  = {wdata[B_EN2],  wdata[B_EN1]};
      pol_d = {wdata[B_POL2], wdata[B_POL1]};
      men_d = wdata[B_MEN];
      swi_d = wdata[B_SWI];
    end
    if (wr_hi) begin
      edge_d = {wdata[B_EDGE2], wdata[B_EDGE1]};
    end
    clr = wr_hi ? {wdata[B_CLR2], wdata[B_CLR1]} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '0;
      edge_q <= '0;
      men_q  <= 1'b0;
      swi_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      pol_q  <= pol_d;
      edge_q <= edge_d;
      men_q  <= men_d;
      swi_q  <= swi_d;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_cfg
      assign cfg[g].en       = en_q[g];
      assign cfg[g].pol_high = pol_q[g];
      assign cfg[g].edge_md  = edge_q[g];
    end
  endgenerate

  assign men = men_q;
  assign swi = swi_q;

  always_comb begin
    rdata          = '0;
    rdata[B_EN1]   = en_q[0];
    rdata[B_POL1]  = pol_q[0];
    rdata[B_STAT1] = status[0];
    rdata[B_EN2]   = en_q[1];
    rdata[B_POL2]  = pol_q[1];
    rdata[B_STAT2] = status[1];
    rdata[B_MEN]   = men_q;
    rdata[B_SWI]   = swi_q;
    rdata[B_EDGE1] = edge_q[0];
    rdata[B_EDGE2] = edge_q[1];
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata[REG_W-1:12], wdata[B_STAT1], wdata[B_STAT2], be[BE_W-1:2]};

  assert_byte_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr && be[1])) |=> $stable(edge_q));

  assert_clr_only_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |-> (wr && be[1]));
endmodule

// File: rtl/lirq_unit.sv
module lirq_unit
  import lirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         irq_raw,
  input  logic               reg_wr,
  input  logic [31:0]        reg_wdata,
  input  logic [3:0]         reg_be,
  output logic [31:0]        reg_rdata,
  output logic               irq_out_n
);
  logic                   rst_n_s;
  logic [NUM_SRC-1:0]     line_s;
  logic [NUM_SRC-1:0]     req;
  logic [NUM_SRC-1:0]     clr;
  src_cfg_t [NUM_SRC-1:0] cfg;
  logic                   men;
  logic                   swi;
  logic                   irq_n_q, irq_n_d;

  lirq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  lirq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .async_in (irq_raw),
    .sync_out (line_s)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_src
      lirq_source u_src (
        .clk    (clk),
        .rst_n  (rst_n_s),
        .line_s (line_s[g]),
        .cfg    (cfg[g]),
        .clr    (clr[g]),
        .req    (req[g])
      );
    end
  endgenerate

  lirq_csr u_csr (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .wr     (reg_wr),
    .wdata  (reg_wdata),
    .be     (reg_be),
    .status (req),
    .cfg    (cfg),
    .clr    (clr),
    .men    (men),
    .swi    (swi),
    .rdata  (reg_rdata)
  );

  always_comb begin
    irq_n_d = ~(men & ((|req) | swi));
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) irq_n_q <= 1'b1;
    else          irq_n_q <= irq_n_d;
  end

  assign irq_out_n = irq_n_q;

  assert_master_gate_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!men) |=> irq_out_n);

  assert_sw_request_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (men && swi) |=> !irq_out_n);

  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!cfg[0].en && !cfg[1].en && !swi) |=> irq_out_n);
endmodule

// File: tb/lirq_unit_tb.sv
module lirq_unit_tb;
  localparam time TCK = 20ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  irq_raw;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [3:0]  reg_be;
  logic [31:0] reg_rdata;
  logic        irq_out_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct {
    string       tag;
    logic [31:0] rd;
    logic        irq_n;
  } exp_t;
  exp_t sb_q[$];

  always #(TCK/2) clk = ~clk;

  lirq_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_raw   (irq_raw),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_be    (reg_be),
    .reg_rdata (reg_rdata),
    .irq_out_n (irq_out_n)
  );

  // Monitor: compares one expected item per falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_chk++;
      if (reg_rdata !== e.rd || irq_out_n !== e.irq_n) begin
        n_fail++;
        $display("FAIL %s: rdata=%h exp=%h irq_out_n=%b exp=%b",
                 e.tag, reg_rdata, e.rd, irq_out_n, e.irq_n);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic expect_item(input string tag, input logic [31:0] rd, input logic irq_n);
    exp_t e;
    e.tag = tag; e.rd = rd; e.irq_n = irq_n;
    sb_q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  // Drives a write that takes effect at the next rising edge; returns 2 ns after it
  task automatic wr(input logic [31:0] d, input logic [3:0] be);
    reg_wr = 1'b1; reg_wdata = d; reg_be = be;
    @(posedge clk);
    #2;
    reg_wr = 1'b0; reg_wdata = '0; reg_be = '0;
  endtask

  initial begin
    #(TCK * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_raw = 2'b00; reg_wr = 1'b0; reg_wdata = '0; reg_be = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    expect_item("R1 reset state", 32'h0, 1'b1);

    // Line 1, level, active-high, master on
    wr(32'h43, 4'b0011);
    tick(2);
    expect_item("R2 idle low", 32'h43, 1'b1);
    tick(1);
    irq_raw[0] = 1'b1;
    expect_item("R12 before edge 1", 32'h43, 1'b1);
    tick(1);
    expect_item("R12 after edge 1", 32'h43, 1'b1);
    tick(1);
    expect_item("R12 status after edge 2", 32'h47, 1'b1);
    tick(1);
    expect_item("R12 output after edge 3", 32'h47, 1'b0);
    irq_raw[0] = 1'b0;
    tick(4);
    expect_item("R2 line low releases", 32'h43, 1'b1);

    // Active-low polarity
    wr(32'h41, 4'b0011);
    tick(2);
    expect_item("R3 low line active", 32'h45, 1'b0);
    irq_raw[0] = 1'b1;
    tick(4);
    expect_item("R3 high line idle", 32'h41, 1'b1);
    irq_raw[0] = 1'b0;
    tick(4);
    wr(32'h40, 4'b0011);
    tick(2);
    expect_item("R4 disabled line quiet", 32'h40, 1'b1);

    // Master enable gating and registered output
    wr(32'h01, 4'b0011);
    tick(2);
    expect_item("R5 master off", 32'h05, 1'b1);
    wr(32'h41, 4'b0011);
    expect_item("R12 output lags status", 32'h45, 1'b1);
    tick(1);
    expect_item("R5 master on asserts", 32'h45, 1'b0);

    // Software request
    wr(32'hC0, 4'b0011);
    tick(2);
    expect_item("R6 software asserts", 32'hC0, 1'b0);
    wr(32'h80, 4'b0011);
    tick(2);
    expect_item("R5 software gated", 32'h80, 1'b1);

    // Line 2 latched mode, polarity 0 (ignored)
    wr(32'h248, 4'b0011);
    tick(3);
    expect_item("R7 polarity ignored", 32'h248, 1'b1);
    irq_raw[1] = 1'b1;
    tick(4);
    expect_item("R7 rising edge latched", 32'h268, 1'b0);
    irq_raw[1] = 1'b0;
    tick(4);
    expect_item("R7 latch holds", 32'h268, 1'b0);
    wr(32'hA48, 4'b0011);
    tick(2);
    expect_item("R8 clear command", 32'h248, 1'b1);

    // Rise and clear in the same cycle
    irq_raw[1] = 1'b1;
    tick(1);
    tick(1);
    wr(32'hA48, 4'b0011);
    tick(2);
    expect_item("R9 rise beats clear", 32'h268, 1'b0);
    wr(32'hA48, 4'b0011);
    tick(2);
    expect_item("R8 clear with line held high", 32'h248, 1'b1);

    // Disable clears latch
    irq_raw[1] = 1'b0;
    tick(3);
    irq_raw[1] = 1'b1;
    tick(4);
    expect_item("R10 relatched", 32'h268, 1'b0);
    wr(32'h240, 4'b0011);
    tick(2);
    expect_item("R10 disabled", 32'h240, 1'b1);
    wr(32'h248, 4'b0011);
    tick(2);
    expect_item("R10 no resurrection", 32'h248, 1'b1);

    // Byte enables and reserved bits
    wr(32'hFFFF_FFFF, 4'b0010);
    tick(2);
    expect_item("R11 byte 0 untouched", 32'h348, 1'b1);
    wr(32'hFFFF_FFFF, 4'b0001);
    tick(2);
    expect_item("R13 reserved and status read 0", 32'h3DB, 1'b0);
    wr(32'h0, 4'b1111);
    tick(2);
    expect_item("R11 full clear", 32'h0, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule